// File: doc/BRIEF.md
# TIS Response Receive Engine

This block is a bus master that collects a finished response from a trusted-platform device after a command has run. Once started, it reads the device's status register until a response is ready. It then empties the device's data register one byte at a time and stores each byte in a local buffer, with the byte's offset as the buffer address. The number of bytes the device may give without a new status read is the burst value that the status word reports.

The total response length is not known when the read begins. The engine first assumes the response fills the whole buffer. When the sixth byte arrives, it replaces that limit with a 32-bit big-endian length carried in bytes 2 to 5 of the response header. That length must be at least six and must fit the buffer. When the count is reached, the engine checks that the device holds no more data. It then releases the device by writing the command-ready bit back to the status register.

Every wait on the status register is bounded. There is an idle gap of a set number of cycles between polls, and a limit on the number of polls. Each run ends with a one-cycle done pulse that carries an error code and the number of bytes stored.

Top module: `tis_rx_engine`

## Requirements
- R1: After `start`, the engine reads the status register (`bus_sel`=0) until bit 7 (valid) and bit 4 (data available) are both 1. Bit 7 alone is not enough. Polls are spaced by POLL_GAP idle cycles. If POLL_LIMIT reads all fail, the run ends with error 1 and count 0.
- R2: The burst value is status bits 23:8. When it is zero, the engine polls the status register again. If POLL_LIMIT further reads all return zero, the run ends with error 2.
- R3: Each byte read from the data register (`bus_sel`=1, bits 7:0) is written to the buffer once, in arrival order, at address equal to its offset. No more bytes are read per status word than its burst value.
- R4: The byte limit starts at `capacity`. When the sixth byte is stored, the limit becomes the value of bytes 2..5, with byte 2 as the most significant byte. No data read is made once the limit is reached.
- R5: If the header length is below 6 or above `capacity`, the run ends with error 3 and count 6, and no release write is made.
- R6: After each burst, the engine polls the status register until bit 7 is set. If POLL_LIMIT reads fail, the run ends with error 4, and the count is the number of bytes stored so far.
- R7: If the limit is reached and the following valid status still shows data available, the run ends with error 5.
- R8: If a valid status shows data available clear before the limit is reached, the run ends successfully with the bytes stored so far.
- R9: On success, the engine writes 0x00000040 once to the status register. After that write is accepted, `done` pulses with error 0 and the byte count.
- R10: A bus request stays asserted, with `bus_sel` and `bus_we` unchanged, until `bus_ack`.
- R11: If `capacity` is below 6, the header is never parsed and reading stops at `capacity` bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a receive run (taken when idle) |
| capacity | input | CNT_W | Buffer size in bytes, captured at start |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_sel | output | 1 | 0 = status register, 1 = data register |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access accepted; read data valid |
| bus_rdata | input | 32 | Read data |
| buf_we | output | 1 | Buffer write strobe |
| buf_addr | output | CNT_W | Buffer write address (byte offset) |
| buf_wdata | output | 8 | Buffer write byte |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 3 | Result code: 0 ok, 1 not ready, 2 stuck, 3 size, 4 valid lost, 5 bad message |
| rx_count | output | CNT_W | Bytes stored in the last run |

## Verification
Two events can fall on the same data acknowledge: the sixth byte completes the header, and the current burst runs out. In that cycle the limit can also fall to exactly the bytes already read. The bench provokes this with a burst of six and a header length of six, and expects a plain success of six bytes with no extra data read. A second overlap is between reaching the limit and a status word that still shows data available. A device holding more bytes than the header states must give error 5, while a device that runs dry early must give a short success. The reference model works out each outcome from the capacity, the header length and the bytes available, and checks every buffer write on the clock it occurs.

// File: rtl/tis_rx_pkg.sv
package tis_rx_pkg;

  typedef enum logic [2:0] {
    RX_OK      = 3'd0,
    RX_RDY_TMO = 3'd1,
    RX_STUCK   = 3'd2,
    RX_SIZE    = 3'd3,
    RX_VLD_TMO = 3'd4,
    RX_BADMSG  = 3'd5
  } rx_err_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RDY,
    ST_RGAP,
    ST_ZGAP,
    ST_ZRD,
    ST_DAT,
    ST_VLD,
    ST_VGAP,
    ST_REL
  } rx_state_e;

  localparam int unsigned STS_VALID_BIT = 7;
  localparam int unsigned STS_AVAIL_BIT = 4;
  localparam int unsigned STS_BURST_LSB = 8;
  localparam int unsigned STS_BURST_W   = 16;
  localparam logic [31:0] STS_CMD_READY = 32'h0000_0040;
  localparam int unsigned HDR_BYTES     = 6;

endpackage

// File: rtl/tis_rx_pacer.sv
module tis_rx_pacer #(
  parameter int unsigned POLL_GAP   = 250,
  parameter int unsigned POLL_LIMIT = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic miss,
  input  logic arm,
  output logic gap_done,
  output logic last
);
  localparam int unsigned PW = $clog2(POLL_LIMIT + 1);
  localparam int unsigned GW = $clog2(POLL_GAP + 2);

  logic [PW-1:0] poll_q, poll_d;
  logic [GW-1:0] gap_q, gap_d;

  always_comb begin
    poll_d = poll_q;
    if (clr)       poll_d = '0;
    else if (miss) poll_d = poll_q + 1'b1;
    gap_d = gap_q;
    if (arm)                gap_d = GW'(POLL_GAP);
    else if (gap_q != '0)   gap_d = gap_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_q <= '0;
      gap_q  <= '0;
    end else begin
      poll_q <= poll_d;
      gap_q  <= gap_d;
    end
  end

  assign gap_done = (gap_q == '0);
  assign last     = (poll_q == PW'(POLL_LIMIT - 1));

  // R1
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_q < PW'(POLL_LIMIT));

endmodule

// File: rtl/tis_rx_hdr.sv
module tis_rx_hdr #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic [CNT_W-1:0] offset,
  input  logic [7:0]       byte_in,
  input  logic [CNT_W-1:0] capacity,
  output logic [31:0]      hdr_len,
  output logic             hdr_bad
);
  localparam int unsigned LEN_FIRST = 2;
  localparam int unsigned LEN_LAST  = 5;

  logic [31:0] len_q, len_d;
  logic        in_field;

  assign in_field = (offset >= CNT_W'(LEN_FIRST)) && (offset <= CNT_W'(LEN_LAST));

  always_comb begin
    len_d = len_q;
    if (clr)                   len_d = '0;
    else if (take && in_field) len_d = {len_q[23:0], byte_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= '0;
    else        len_q <= len_d;
  end

  // The last length byte is combined directly so the check lands on its acknowledge.
  assign hdr_len = {len_q[23:0], byte_in};
  assign hdr_bad = (hdr_len < 32'd6) || (hdr_len > 32'(capacity));

endmodule

// File: rtl/tis_rx_engine.sv
module tis_rx_engine
  import tis_rx_pkg::*;
#(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned POLL_GAP   = 250,
  parameter int unsigned POLL_LIMIT = 1000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] capacity,
  output logic             bus_req,
  output logic             bus_we,
  output logic             bus_sel,
  output logic [31:0]      bus_wdata,
  input  logic             bus_ack,
  input  logic [31:0]      bus_rdata,
  output logic             buf_we,
  output logic [CNT_W-1:0] buf_addr,
  output logic [7:0]       buf_wdata,
  output logic             busy,
  output logic             done,
  output logic [2:0]       err,
  output logic             [CNT_W-1:0] rx_count
);
  localparam logic [CNT_W-1:0] LAST_HDR_OFS = CNT_W'(HDR_BYTES - 1);

  rx_state_e               state_q, state_d;
  logic [CNT_W-1:0]        ofs_q, ofs_d, lim_q, lim_d, cap_q, cap_d;
  logic [STS_BURST_W-1:0]  burst_q, burst_d;
  rx_err_e                 err_q, err_d;
  logic                    done_q, done_d;
  logic                    bwe_q, bwe_d;
  logic [CNT_W-1:0]        baddr_q;
  logic [7:0]              bdata_q;

  logic p_clr, p_miss, p_arm, gap_done, poll_last;
  logic h_clr, h_take, hdr_bad;
  logic [31:0] hdr_len;

  logic                   st_valid, st_avail;
  logic [STS_BURST_W-1:0] st_burst;
  logic                   dat_go;

  assign st_valid = bus_rdata[STS_VALID_BIT];
  assign st_avail = bus_rdata[STS_AVAIL_BIT];
  assign st_burst = bus_rdata[STS_BURST_LSB +: STS_BURST_W];
  assign dat_go   = (burst_q != '0) && (ofs_q < lim_q);

  tis_rx_pacer #(.POLL_GAP(POLL_GAP), .POLL_LIMIT(POLL_LIMIT)) pacer_i (
    .clk(clk), .rst_n(rst_n), .clr(p_clr), .miss(p_miss), .arm(p_arm),
    .gap_done(gap_done), .last(poll_last)
  );

  tis_rx_hdr #(.CNT_W(CNT_W)) hdr_i (
    .clk(clk), .rst_n(rst_n), .clr(h_clr), .take(h_take), .offset(ofs_q),
    .byte_in(bus_rdata[7:0]), .capacity(cap_q), .hdr_len(hdr_len), .hdr_bad(hdr_bad)
  );

  always_comb begin
    state_d = state_q;  ofs_d = ofs_q;  lim_d = lim_q;  cap_d = cap_q;
    burst_d = burst_q;  err_d = err_q;  done_d = 1'b0;  bwe_d = 1'b0;
    p_clr = 1'b0;  p_miss = 1'b0;  p_arm = 1'b0;  h_clr = 1'b0;  h_take = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        ofs_d = '0;  lim_d = capacity;  cap_d = capacity;  err_d = RX_OK;
        p_clr = 1'b1;  h_clr = 1'b1;  state_d = ST_RDY;
      end
      ST_RDY: if (bus_ack) begin
        if (st_valid && st_avail) begin
          p_clr = 1'b1;  burst_d = st_burst;
          if (st_burst == '0) begin p_arm = 1'b1; state_d = ST_ZGAP; end
          else state_d = ST_DAT;
        end else if (poll_last) begin
          err_d = RX_RDY_TMO;  done_d = 1'b1;  state_d = ST_IDLE;
        end else begin
          p_miss = 1'b1;  p_arm = 1'b1;  state_d = ST_RGAP;
        end
      end
      ST_RGAP: if (gap_done) state_d = ST_RDY;
      ST_ZGAP: if (gap_done) state_d = ST_ZRD;
      ST_ZRD: if (bus_ack) begin
        if (st_burst != '0) begin
          p_clr = 1'b1;  burst_d = st_burst;  state_d = ST_DAT;
        end else if (poll_last) begin
          err_d = RX_STUCK;  done_d = 1'b1;  state_d = ST_IDLE;
        end else begin
          p_miss = 1'b1;  p_arm = 1'b1;  state_d = ST_ZGAP;
        end
      end
      ST_DAT: begin
        if (!dat_go) begin
          p_clr = 1'b1;  state_d = ST_VLD;
        end else if (bus_ack) begin
          bwe_d = 1'b1;  h_take = 1'b1;
          ofs_d = ofs_q + 1'b1;  burst_d = burst_q - 1'b1;
          if (ofs_q == LAST_HDR_OFS) begin
            if (hdr_bad) begin
              err_d = RX_SIZE;  done_d = 1'b1;  state_d = ST_IDLE;
            end else lim_d = hdr_len[CNT_W-1:0];
          end
        end
      end
      ST_VLD: if (bus_ack) begin
        if (!st_valid) begin
          if (poll_last) begin
            err_d = RX_VLD_TMO;  done_d = 1'b1;  state_d = ST_IDLE;
          end else begin
            p_miss = 1'b1;  p_arm = 1'b1;  state_d = ST_VGAP;
          end
        end else if (ofs_q == lim_q) begin
          if (st_avail) begin
            err_d = RX_BADMSG;  done_d = 1'b1;  state_d = ST_IDLE;
          end else state_d = ST_REL;
        end else if (!st_avail) begin
          state_d = ST_REL;
        end else begin
          p_clr = 1'b1;  burst_d = st_burst;
          if (st_burst == '0) begin p_arm = 1'b1; state_d = ST_ZGAP; end
          else state_d = ST_DAT;
        end
      end
      ST_VGAP: if (gap_done) state_d = ST_VLD;
      ST_REL: if (bus_ack) begin
        err_d = RX_OK;  done_d = 1'b1;  state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;  ofs_q <= '0;  lim_q <= '0;  cap_q <= '0;
      burst_q <= '0;  err_q <= RX_OK;  done_q <= 1'b0;  bwe_q <= 1'b0;
      baddr_q <= '0;  bdata_q <= '0;
    end else begin
      state_q <= state_d;  ofs_q <= ofs_d;  lim_q <= lim_d;  cap_q <= cap_d;
      burst_q <= burst_d;  err_q <= err_d;  done_q <= done_d;  bwe_q <= bwe_d;
      if (bwe_d) begin
        baddr_q <= ofs_q;
        bdata_q <= bus_rdata[7:0];
      end
    end
  end

  assign bus_req = (state_q == ST_RDY) || (state_q == ST_ZRD) || (state_q == ST_VLD) ||
                   (state_q == ST_REL) || ((state_q == ST_DAT) && dat_go);
  assign bus_sel   = (state_q == ST_DAT);
  assign bus_we    = (state_q == ST_REL);
  assign bus_wdata = (state_q == ST_REL) ? STS_CMD_READY : 32'h0;
  assign buf_we    = bwe_q;
  assign buf_addr  = baddr_q;
  assign buf_wdata = bdata_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign rx_count  = ofs_q;

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_sel) && $stable(bus_we)));

  // R9
  release_before_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err == RX_OK) |-> $past(bus_req && bus_we && bus_ack));

  // R5
  size_at_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err == RX_SIZE) |-> (rx_count == CNT_W'(HDR_BYTES)));

  // R4
  within_capacity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ofs_q <= cap_q));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/tis_rx_engine_tb_top.sv
module tis_rx_engine_tb_top;
  localparam int CNT_W = 12;
  localparam int GAP   = 3;
  localparam int LIMIT = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] capacity = '0;
  logic bus_req, bus_we, bus_sel, buf_we, busy, done;
  logic [31:0] bus_wdata;
  logic bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic [CNT_W-1:0] buf_addr, rx_count;
  logic [7:0] buf_wdata;
  logic [2:0] err;

  always #2 clk = ~clk;

  tis_rx_engine #(.CNT_W(CNT_W), .POLL_GAP(GAP), .POLL_LIMIT(LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .capacity(capacity),
    .bus_req(bus_req), .bus_we(bus_we), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .busy(busy), .done(done), .err(err), .rx_count(rx_count)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(string req, bit ok, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // device model
  logic [7:0] dev_q[$];
  logic [7:0] exp_q[$];
  int rdy_wait, zero_polls, burst_cfg, st_reads, rel_writes, mon_idx;
  bit vld_dead, seen_data;

  always @(negedge clk) begin
    if (bus_ack) bus_ack = 1'b0;
    else if (bus_req) begin
      bus_ack = 1'b1;
      if (bus_we) begin
        if (bus_sel == 1'b0 && bus_wdata == 32'h40) rel_writes++;
        else rel_writes += 100;
      end else if (bus_sel) begin
        seen_data = 1'b1;
        bus_rdata = (dev_q.size() > 0) ? {24'h0, dev_q.pop_front()} : 32'hFF;
      end else begin
        int b;
        st_reads++;
        b = (dev_q.size() < burst_cfg) ? dev_q.size() : burst_cfg;
        if (rdy_wait > 0) begin
          rdy_wait--;
          bus_rdata = 32'h80;
        end else if (vld_dead && seen_data) begin
          bus_rdata = 32'h10;
        end else if (zero_polls > 0) begin
          zero_polls--;
          bus_rdata = 32'h80 | ((dev_q.size() > 0) ? 32'h10 : 32'h0);
        end else begin
          bus_rdata = {8'h0, 16'(b), 8'h80 | ((dev_q.size() > 0) ? 8'h10 : 8'h00)};
        end
      end
    end
  end

  // per-clock buffer-write comparison against the expected byte stream
  always @(negedge clk) begin
    if (rst_n && buf_we) begin
      if (mon_idx < exp_q.size())
        chk("R3 buf_data", buf_wdata == exp_q[mon_idx], buf_wdata, exp_q[mon_idx]);
      else
        chk("R3 extra_write", 1'b0, mon_idx, exp_q.size());
      chk("R3 buf_addr", buf_addr == CNT_W'(mon_idx), buf_addr, mon_idx);
      mon_idx++;
    end
  end

  function automatic void ref_model(int cap, int len, int avail, output int e, output int c);
    int lim = cap;
    int off = 0;
    e = 0;
    while (off < lim && off < avail) begin
      off++;
      if (off == 6) begin
        if (len < 6 || len > cap) begin e = 3; c = off; return; end
        lim = len;
      end
    end
    c = off;
    e = (off == lim && avail > off) ? 5 : 0;
  endfunction

  int cyc = 0;
  bit wd_hit = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !wd_hit) begin
      wd_hit = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_case(string tag, int cap, int len, int avail, int burst, int rw,
                          int zp, bit vd, bit use_ref, int xerr, int xcnt, int xreads);
    int e, c, w;
    if (use_ref) ref_model(cap, len, avail, e, c);
    else begin e = xerr; c = xcnt; end
    dev_q.delete(); exp_q.delete();
    for (int i = 0; i < avail; i++) begin
      logic [7:0] v;
      if (i >= 2 && i <= 5) v = 8'(len >> (8 * (5 - i)));
      else v = 8'(i * 7 + 3 + cap);
      dev_q.push_back(v);
      if (i < c) exp_q.push_back(v);
    end
    rdy_wait = rw; zero_polls = zp; burst_cfg = burst; vld_dead = vd;
    seen_data = 0; st_reads = 0; rel_writes = 0; mon_idx = 0;
    capacity = CNT_W'(cap);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    w = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    chk({tag, " done"}, done == 1'b1, done, 1);
    chk({tag, " err"}, int'(err) == e, err, e);
    chk({tag, " count"}, int'(rx_count) == c, rx_count, c);
    @(negedge clk);
    chk({tag, " R3 writes"}, mon_idx == c, mon_idx, c);
    // R9: release write only on success
    chk({tag, " R9 release"}, rel_writes == ((e == 0) ? 1 : 0), rel_writes, (e == 0) ? 1 : 0);
    if (xreads > 0) chk({tag, " status_reads"}, st_reads == xreads, st_reads, xreads);
    chk({tag, " idle"}, busy == 1'b0 && done == 1'b0, busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset state", !busy && !done && !bus_req && !buf_we, {busy, done, bus_req}, 0);
    // R1 R3 R9: ready after valid-only polls, bursts of 4
    run_case("R1 normal", 32, 10, 10, 4, 3, 0, 0, 1, 0, 0, 0);
    // R4: header ends exactly with the burst, length six
    run_case("R4 hdr_eq_burst", 32, 6, 6, 6, 0, 0, 0, 1, 0, 0, 0);
    // R5: length above capacity, and below six
    run_case("R5 too_long", 32, 40, 40, 8, 0, 0, 0, 1, 0, 0, 0);
    run_case("R5 too_short", 32, 5, 12, 8, 0, 0, 0, 1, 0, 0, 0);
    // R7: device holds more than header states
    run_case("R7 extra", 32, 8, 12, 5, 0, 0, 0, 1, 0, 0, 0);
    // R8: device runs dry before limit
    run_case("R8 short", 32, 12, 8, 4, 0, 0, 0, 1, 0, 0, 0);
    // R11: capacity below header size
    run_case("R11 small_cap", 4, 4, 4, 8, 0, 0, 0, 1, 0, 0, 0);
    // R4: length equal to capacity
    run_case("R4 full", 32, 32, 32, 7, 1, 0, 0, 1, 0, 0, 0);
    // R2: a few zero bursts then recovery
    run_case("R2 recover", 32, 9, 9, 3, 0, 5, 0, 1, 0, 0, 0);
    // R1: never ready
    run_case("R1 timeout", 32, 9, 9, 3, 1000, 0, 0, 0, 1, 0, LIMIT);
    // R2: burst stuck at zero
    run_case("R2 stuck", 32, 9, 9, 3, 0, 1000, 0, 0, 2, 0, LIMIT + 1);
    // R6: valid lost after first burst
    run_case("R6 vld_lost", 32, 10, 10, 4, 0, 0, 1, 0, 4, 4, LIMIT + 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule